// File: doc/BRIEF.md
# UART Byte Queues with Threshold Flags

This block holds the byte queues that sit between a UART's serializer and deserializer and the software that feeds and drains them. The transmit queue is filled through a byte write port and emptied by the serializer one byte at a time. The receive queue is filled by the deserializer and emptied through a pop port, which returns a registered byte. Each queue can run at its full built depth or drop back to a one-entry holding buffer. The choice is made by its own enable bit.

Two status flags tell software when to act. The transmit flag is raised while the transmit fill level is at or below a programmable threshold. The receive flag is raised while the receive fill level is at or above a second threshold. A small register window holds the control bits and both thresholds. It also reports a 3-bit logarithmic code for each queue's effective size, the sticky error bits and both fill levels. Threshold and queue-enable changes are refused while the transmitter or receiver is switched on.

Top module: `uart_fifo_wm`

## Requirements
- R1: After reset the control register (address 0) reads 0, the transmit threshold (address 1) reads 0, the receive threshold (address 2) reads 1, both fill counts (addresses 5 and 6) read 0, `tdre` is 1 and `rdrf` is 0.
- R2: Address 3 is read-only. Bits [2:0] hold the transmit size code and bits [6:4] hold the receive size code. A code is 0 (one entry) when that queue is disabled. Otherwise it is the built depth encoded as 1→0, 4→1, 8→2, 16→3, 32→4, 64→5, 128→6. The default build is 8 deep, so an enabled queue reports 2.
- R3: `tdre` (also status bit 0 at address 4) is 1 exactly when the transmit fill count is less than or equal to the transmit threshold.
- R4: `rdrf` (also status bit 1) is 1 exactly when the receive fill count is greater than or equal to the receive threshold.
- R5: Control bit 2 enables the transmit queue and bit 3 enables the receive queue. A disabled queue holds one byte and an enabled queue holds its built depth. Bytes leave a queue in the order they entered it.
- R6: A transmit write while the transmit queue is full is dropped and sets sticky status bit 2. Writing 1 to bit 2 at address 4 clears it.
- R7: A receive pop while the receive queue is empty leaves `rx_rdata` unchanged and sets sticky status bit 3. Writing 1 to bit 3 at address 4 clears it.
- R8: While control bit 0 (transmitter on) or bit 1 (receiver on) is set, writes to both thresholds and to the queue-enable bits are ignored. Bits 0 and 1 themselves stay writable.
- R9: An accepted control write that changes either queue-enable bit empties both queues. A control write that leaves the enable bits unchanged keeps their contents.
- R10: Addresses 5 and 6 read the current transmit and receive fill counts.
- R11: A receive byte offered while the receive queue is full is dropped and the count stays at the queue's depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational on cfg_addr) |
| tx_wr | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Transmit byte |
| tx_take | input | 1 | Serializer removes the head transmit byte |
| tx_head | output | 8 | Head byte of the transmit queue |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_put | input | 1 | Deserializer offers a received byte |
| rx_pdata | input | 8 | Received byte |
| rx_pop | input | 1 | Software removes the head receive byte |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| tdre | output | 1 | Transmit fill at or below its threshold |
| rdrf | output | 1 | Receive fill at or above its threshold |

## Verification
A corrupted fill counter appears at the ports on the next read of the count register, and it also flips `tdre` or `rdrf` at the first threshold the wrong value crosses. The bench therefore sweeps every threshold against every fill level and checks the flags one cycle after each push. A wrong pointer shows up as a byte out of order on `tx_head` or `rx_rdata` during the following drain. A lock or flush fault shows up on the next register read-back or count read.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_TXWM  = 3'd1;
  localparam logic [REG_AW-1:0] A_RXWM  = 3'd2;
  localparam logic [REG_AW-1:0] A_SIZE  = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd4;
  localparam logic [REG_AW-1:0] A_TXCNT = 3'd5;
  localparam logic [REG_AW-1:0] A_RXCNT = 3'd6;

  localparam int ST_TDRE = 0;
  localparam int ST_RDRF = 1;
  localparam int ST_TOVF = 2;
  localparam int ST_RUNF = 3;

  typedef struct packed {
    logic rxq_en;
    logic txq_en;
    logic rx_on;
    logic tx_on;
  } ctrl_t;

  // log2 depth to size code: 1->0, 4->1, 8->2 ... 128->6
  function automatic logic [2:0] size_code(input int lg);
    if (lg < 2) return 3'd0;
    return 3'(lg - 1);
  endfunction

endpackage

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
  parameter int LG = 3,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_en,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LG:0]   count,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << LG;
  localparam int CW    = LG + 1;
  localparam int PW    = (LG == 0) ? 1 : LG;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d, eff_depth;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p,
                                         input logic [CW-1:0] lim);
    if (CW'(p) == lim - CW'(1)) return '0;
    return p + PW'(1);
  endfunction

  always_comb begin
    eff_depth = q_en ? CW'(DEPTH) : CW'(1);
    full      = (count_q == eff_depth);
    empty     = (count_q == '0);
    push_ok   = push && !full;
    pop_ok    = pop && !empty;
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    count_d   = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = step(wr_ptr_q, eff_depth);
      if (pop_ok)  rd_ptr_d = step(rd_ptr_q, eff_depth);
      case ({push_ok, pop_ok})
        2'b10:   count_d = count_q + CW'(1);
        2'b01:   count_d = count_q - CW'(1);
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr_q] <= wdata;
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= eff_depth);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));

endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
  import uart_fifo_pkg::*;
#(
  parameter int TX_LG = 3,
  parameter int RX_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_DW-1:0] cfg_wdata,
  output logic [REG_DW-1:0] cfg_rdata,
  input  logic [TX_LG:0]    tx_count,
  input  logic [RX_LG:0]    rx_count,
  input  logic              tx_ovf_evt,
  input  logic              rx_unf_evt,
  output ctrl_t             ctrl,
  output logic              flush,
  output logic              tdre,
  output logic              rdrf
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [REG_DW-1:0] txwm_q, txwm_d, rxwm_q, rxwm_d;
  logic              ovf_q, ovf_d, unf_q, unf_d;
  logic              locked, wr_ctrl, wr_stat;
  ctrl_t             wr_val;

  always_comb begin
    locked  = ctrl_q.tx_on | ctrl_q.rx_on;
    wr_ctrl = cfg_wr && (cfg_addr == A_CTRL);
    wr_stat = cfg_wr && (cfg_addr == A_STAT);
    wr_val  = ctrl_t'(cfg_wdata[3:0]);

    ctrl_d = ctrl_q;
    flush  = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.tx_on = wr_val.tx_on;
      ctrl_d.rx_on = wr_val.rx_on;
      if (!locked) begin
        ctrl_d.txq_en = wr_val.txq_en;
        ctrl_d.rxq_en = wr_val.rxq_en;
        flush = (wr_val.txq_en != ctrl_q.txq_en) ||
                (wr_val.rxq_en != ctrl_q.rxq_en);
      end
    end

    txwm_d = txwm_q;
    rxwm_d = rxwm_q;
    if (cfg_wr && !locked && (cfg_addr == A_TXWM)) txwm_d = cfg_wdata;
    if (cfg_wr && !locked && (cfg_addr == A_RXWM)) rxwm_d = cfg_wdata;

    ovf_d = (ovf_q && !(wr_stat && cfg_wdata[ST_TOVF])) || tx_ovf_evt;
    unf_d = (unf_q && !(wr_stat && cfg_wdata[ST_RUNF])) || rx_unf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      txwm_q <= '0;
      rxwm_q <= REG_DW'(1);
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      txwm_q <= txwm_d;
      rxwm_q <= rxwm_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  assign tdre = (9'(tx_count) <= 9'(txwm_q));
  assign rdrf = (9'(rx_count) >= 9'(rxwm_q));
  assign ctrl = ctrl_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTRL:  cfg_rdata = {4'b0, ctrl_q};
      A_TXWM:  cfg_rdata = txwm_q;
      A_RXWM:  cfg_rdata = rxwm_q;
      A_SIZE:  cfg_rdata = {1'b0, ctrl_q.rxq_en ? size_code(RX_LG) : 3'd0,
                            1'b0, ctrl_q.txq_en ? size_code(TX_LG) : 3'd0};
      A_STAT:  cfg_rdata = {4'b0, unf_q, ovf_q, rdrf, tdre};
      A_TXCNT: cfg_rdata = REG_DW'(tx_count);
      A_RXCNT: cfg_rdata = REG_DW'(rx_count);
      default: cfg_rdata = '0;
    endcase
  end

  // R8
  wm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(txwm_q) && $stable(rxwm_q)));

  // R8
  qen_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(ctrl_q.txq_en) && $stable(ctrl_q.rxq_en)));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_evt |=> ovf_q);

endmodule

// File: rtl/uart_fifo_wm.sv
module uart_fifo_wm
  import uart_fifo_pkg::*;
#(
  parameter int TX_LG = 3,
  parameter int RX_LG = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       tx_wr,
  input  logic [7:0] tx_wdata,
  input  logic       tx_take,
  output logic [7:0] tx_head,
  output logic       tx_avail,
  input  logic       rx_put,
  input  logic [7:0] rx_pdata,
  input  logic       rx_pop,
  output logic [7:0] rx_rdata,
  output logic       tdre,
  output logic       rdrf
);
  logic [TX_LG:0] tx_count;
  logic [RX_LG:0] rx_count;
  logic           tx_full, tx_empty, rx_full, rx_empty, flush;
  logic [7:0]     rx_head, rx_rdata_q, rx_rdata_d;
  ctrl_t          ctrl;

  uart_fifo_regs #(.TX_LG(TX_LG), .RX_LG(RX_LG)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_ovf_evt(tx_wr && tx_full), .rx_unf_evt(rx_pop && rx_empty),
    .ctrl(ctrl), .flush(flush), .tdre(tdre), .rdrf(rdrf)
  );

  uart_fifo_core #(.LG(TX_LG), .W(8)) txq_i (
    .clk(clk), .rst_n(rst_n), .q_en(ctrl.txq_en), .flush(flush),
    .push(tx_wr), .wdata(tx_wdata), .pop(tx_take), .head(tx_head),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_fifo_core #(.LG(RX_LG), .W(8)) rxq_i (
    .clk(clk), .rst_n(rst_n), .q_en(ctrl.rxq_en), .flush(flush),
    .push(rx_put), .wdata(rx_pdata), .pop(rx_pop), .head(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  always_comb begin
    rx_rdata_d = rx_rdata_q;
    if (rx_pop && !rx_empty) rx_rdata_d = rx_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_rdata_q <= '0;
    else        rx_rdata_q <= rx_rdata_d;
  end

  assign rx_rdata = rx_rdata_q;
  assign tx_avail = !tx_empty;

  // R7
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |=> $stable(rx_rdata));

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full && !tx_take && !flush) |=> (tx_count == $past(tx_count)));

  // R11
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_put && rx_full && !rx_pop && !flush) |=> (rx_count == $past(rx_count)));

  // R9
  flush_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_count == '0 && rx_count == '0));

endmodule

// File: tb/uart_fifo_wm_tb_top.sv
module uart_fifo_wm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tx_wr = 1'b0, tx_take = 1'b0, rx_put = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_pdata = '0;
  logic [7:0] tx_head, rx_rdata;
  logic       tx_avail, tdre, rdrf;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_fifo_wm dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_take(tx_take), .tx_head(tx_head),
    .tx_avail(tx_avail), .rx_put(rx_put), .rx_pdata(rx_pdata),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .tdre(tdre), .rdrf(rdrf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic take_tx();
    @(negedge clk); tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  task automatic put_rx(input logic [7:0] b);
    @(negedge clk); rx_put = 1'b1; rx_pdata = b;
    @(negedge clk); rx_put = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 txwm", v, 0);
    rd(3'd2, v); check("R1 rxwm", v, 1);
    rd(3'd5, v); check("R1 txcnt", v, 0);
    rd(3'd6, v); check("R1 rxcnt", v, 0);
    check("R1 tdre", tdre, 1);
    check("R1 rdrf", rdrf, 0);
    rd(3'd3, v); check("R2 size disabled", v, 8'h00);
    rd(3'd4, v); check("R3 status", v, 8'h01);

    // R5 single buffer when disabled, R6 overflow
    push_tx(8'hA1);
    push_tx(8'hB2);
    rd(3'd5, v); check("R5 one entry", v, 1);
    rd(3'd4, v); check("R6 ovf set", v[2], 1);
    check("R3 tdre wm0 cnt1", tdre, 0);
    check("R5 head", tx_head, 8'hA1);
    take_tx();
    check("R3 tdre empty", tdre, 1);
    check("R5 avail", tx_avail, 0);
    wr(3'd4, 8'h04);
    rd(3'd4, v); check("R6 ovf clear", v[2], 0);

    // R11 rx single buffer, R7 underflow
    put_rx(8'h5C);
    check("R4 rdrf one", rdrf, 1);
    put_rx(8'h6D);
    rd(3'd6, v); check("R11 rx drop", v, 1);
    pop_rx();
    check("R5 rx data", rx_rdata, 8'h5C);
    check("R4 rdrf zero", rdrf, 0);
    pop_rx();
    check("R7 hold", rx_rdata, 8'h5C);
    rd(3'd4, v); check("R7 unf set", v[3], 1);
    wr(3'd4, 8'h08);
    rd(3'd4, v); check("R7 unf clear", v[3], 0);

    // R2 enabled size code
    wr(3'd0, 8'h0C);
    rd(3'd3, v); check("R2 size enabled", v, 8'h22);

    // R3 tx threshold sweep
    for (int wm = 0; wm <= 8; wm++) begin
      wr(3'd1, 8'(wm));
      for (int k = 0; k <= 8; k++) begin
        check("R3 tdre sweep", tdre, (k <= wm) ? 1 : 0);
        rd(3'd5, v); check("R10 txcnt", v, k);
        if (k < 8) push_tx(8'(wm * 16 + k));
      end
      push_tx(8'hFF);
      rd(3'd5, v); check("R6 full drop", v, 8);
      rd(3'd4, v); check("R6 ovf full", v[2], 1);
      wr(3'd4, 8'h04);
      for (int k = 0; k < 8; k++) begin
        check("R5 tx order", tx_head, wm * 16 + k);
        take_tx();
      end
      check("R5 tx drained", tx_avail, 0);
    end

    // R4 rx threshold sweep
    for (int wm = 0; wm <= 9; wm++) begin
      wr(3'd2, 8'(wm));
      for (int k = 0; k <= 8; k++) begin
        check("R4 rdrf sweep", rdrf, (k >= wm) ? 1 : 0);
        rd(3'd6, v); check("R10 rxcnt", v, k);
        if (k < 8) put_rx(8'(8'h80 + wm * 8 + k));
      end
      put_rx(8'h00);
      rd(3'd6, v); check("R11 rx full drop", v, 8);
      for (int k = 0; k < 8; k++) begin
        pop_rx();
        check("R5 rx order", rx_rdata, 8'h80 + wm * 8 + k);
      end
    end

    // R8 lock
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    wr(3'd0, 8'h0F);
    wr(3'd1, 8'd5);
    rd(3'd1, v); check("R8 txwm locked", v, 8);
    wr(3'd2, 8'd2);
    rd(3'd2, v); check("R8 rxwm locked", v, 9);
    wr(3'd0, 8'h03);
    rd(3'd0, v); check("R8 qen locked", v, 8'h0F);
    rd(3'd3, v); check("R8 size kept", v, 8'h22);
    rd(3'd5, v); check("R9 no flush locked", v, 3);

    // R9 flush only on enable change
    wr(3'd0, 8'h0C);
    rd(3'd5, v); check("R9 same qen keeps", v, 3);
    put_rx(8'h44); put_rx(8'h55);
    wr(3'd0, 8'h04);
    rd(3'd5, v); check("R9 tx flushed", v, 0);
    rd(3'd6, v); check("R9 rx flushed", v, 0);
    rd(3'd3, v); check("R2 mixed size", v, 8'h02);

    finish_run();
  end
endmodule